// File: doc/BRIEF.md
# Sector-Addressed RAM Disk Port Controller

This block lets a host treat a bank of eight static RAM devices (4 MB in total) as a sector-addressed disk. It is reached through four adjacent I/O port addresses. The host never supplies byte addresses. It loads a sector number into two write-only address registers and then streams bytes through a single data port. An internal 9-bit offset counter walks the 512 bytes of a physical sector. Loading either address register clears the counter, and each data-port access advances it.

The block matches the host I/O address against a base that is set by six switch inputs. From the address registers and the offset counter it forms the 22-bit storage address. The top three bits of that address select one of eight active-low chip selects. The block also drives the shared SRAM address bus and the read and write strobes, and it returns a status byte. While the power-fail reset input is low, no chip select, read strobe or write strobe can assert, so a collapsing supply cannot corrupt stored data. A registered activity output follows data-port traffic.

Top module: `ramdisk_port_ctrl`

## Requirements
- R1: The block answers only when `io_addr[7:2]` equals `base_sw`, where a `base_sw` bit is 1 for an open switch and 0 for a closed one. `io_addr[1:0]` selects the port: 0 is data, 1 is sector-low, 2 is sector-high and 3 is status. Accesses to any other address change nothing and read as 0.
- R2: An `io_wr` to port 1 loads the 8-bit sector-low register. An `io_wr` to port 2 loads the low 5 bits of `io_wdata` into the sector-high register. Either write clears the offset counter to 0.
- R3: The storage address is {sector-high[4:0], sector-low[7:0], offset[8:0]}. Its bits 18:0 appear on `sram_addr`.
- R4: The offset counter advances by one when a data-port read or write ends, meaning the cycle after the strobe drops. From 511 it wraps to 0, and the sector registers do not change.
- R5: Storage address bits 21:19 select `sram_cs_n[k]` for k equal to their value. That one bit goes low only during a data-port access. At most one chip select is ever low.
- R6: While `pfail_rst_n` is low, `sram_cs_n` is all ones and `sram_we_n` and `sram_oe_n` are high, even during data-port accesses.
- R7: `sram_we_n` is low only while `io_wr` targets the data port with power good, and `sram_wdata` carries `io_wdata`. `sram_oe_n` is low only during a data-port `io_rd` with power good.
- R8: A data-port read returns `sram_rdata`. A status read returns `pfail_rst_n` in bit 0, with bits 7:1 zero. Reads of ports 1 and 2 return 0 and do not step the counter. Writes to port 3 change nothing.
- R9: `act_led` is high in the cycle after each clock in which a data-port access is active, and low otherwise.
- R10: A synchronous active-high `rst` clears both sector registers, the offset counter and `act_led`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_sw | input | 6 | Base switch levels, 1 = open; compared with io_addr[7:2] |
| io_addr | input | 8 | Host I/O address |
| io_rd | input | 1 | Host I/O read strobe, active high |
| io_wr | input | 1 | Host I/O write strobe, active high |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data |
| pfail_rst_n | input | 1 | Power-fail reset, low blocks all memory cycles |
| sram_addr | output | 19 | Shared SRAM address bus |
| sram_cs_n | output | 8 | Active-low chip selects, one per device |
| sram_oe_n | output | 1 | Active-low SRAM output enable |
| sram_we_n | output | 1 | Active-low SRAM write strobe |
| sram_wdata | output | 8 | Data to SRAM |
| sram_rdata | input | 8 | Data from SRAM |
| act_led | output | 1 | Activity indicator |

## Verification
The hardest state to reach from the ports is the wrap of the offset counter from 511 to 0 with the sector bits left untouched. Reaching it takes an unbroken run of more than 512 data-port accesses with no address-register write in between. The bench therefore streams 514 mixed reads and writes through each of several sectors. The sectors include the highest chip select and a sector-high value whose unused upper bits are set, and every access is checked against an arithmetic model of the address. Power-fail blocking and the port-decode corners are driven as short sequences, and each is followed by a data access that exposes the counter through `sram_addr`.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  // Port order within the four-address window is host-visible behaviour.
  typedef enum logic [1:0] {
    PORT_DATA = 2'd0,
    PORT_ALO  = 2'd1,
    PORT_AHI  = 2'd2,
    PORT_STAT = 2'd3
  } port_e;
endpackage

// File: rtl/rdp_decode.sv
module rdp_decode
  import rdp_pkg::*;
#(
  parameter int IOA_W = 8
) (
  input  logic [IOA_W-1:0] io_addr,
  input  logic [IOA_W-3:0] base_sw,
  output logic             hit,
  output port_e            port
);
  // Open switch reads 1, closed reads 0: the switch level is the address bit.
  assign hit  = (io_addr[IOA_W-1:2] == base_sw);
  assign port = port_e'(io_addr[1:0]);
endmodule

// File: rtl/rdp_locator.sv
module rdp_locator #(
  parameter int BYTE_W = 9,
  parameter int LO_W   = 8,
  parameter int HI_W   = 5,
  localparam int FULL_W = BYTE_W + LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [LO_W-1:0]   lo_din,
  input  logic [HI_W-1:0]   hi_din,
  input  logic              acc_now,
  output logic [FULL_W-1:0] full_addr
);
  logic [LO_W-1:0]   lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [BYTE_W-1:0] off_q;
  logic              acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '0;
      hi_q  <= '0;
      off_q <= '0;
      acc_q <= 1'b0;
    end else begin
      acc_q <= acc_now;
      if (ld_lo) lo_q <= lo_din;
      if (ld_hi) hi_q <= hi_din;
      if (ld_lo || ld_hi)
        off_q <= '0;
      else if (acc_q && !acc_now)
        off_q <= off_q + 1'b1;  // natural wrap, no carry into sector bits
    end
  end

  assign full_addr = {hi_q, lo_q, off_q};
endmodule

// File: rtl/rdp_sram_side.sv
module rdp_sram_side #(
  parameter int FULL_W  = 22,
  parameter int DEV_W   = 19,
  localparam int CS_BITS = FULL_W - DEV_W,
  localparam int NUM_CS  = 1 << CS_BITS
) (
  input  logic [FULL_W-1:0] full_addr,
  input  logic              rd_go,
  input  logic              wr_go,
  input  logic              pwr_ok,
  output logic [DEV_W-1:0]  sram_addr,
  output logic [NUM_CS-1:0] cs_n,
  output logic              oe_n,
  output logic              we_n
);
  logic [CS_BITS-1:0] dev_sel;
  logic               cyc_en;

  assign sram_addr = full_addr[DEV_W-1:0];
  assign dev_sel   = full_addr[FULL_W-1:DEV_W];
  assign cyc_en    = (rd_go || wr_go) && pwr_ok;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n[i] = !(cyc_en && (dev_sel == CS_BITS'(i)));
  end

  assign oe_n = !(rd_go && pwr_ok);
  assign we_n = !(wr_go && pwr_ok);
endmodule

// File: rtl/ramdisk_port_ctrl.sv
module ramdisk_port_ctrl
  import rdp_pkg::*;
#(
  parameter int IOA_W  = 8,
  parameter int DW     = 8,
  parameter int BYTE_W = 9,
  parameter int LO_W   = 8,
  parameter int HI_W   = 5,
  parameter int DEV_W  = 19,
  localparam int FULL_W  = BYTE_W + LO_W + HI_W,
  localparam int CS_BITS = FULL_W - DEV_W,
  localparam int NUM_CS  = 1 << CS_BITS,
  localparam int BASE_W  = IOA_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BASE_W-1:0] base_sw,
  input  logic [IOA_W-1:0]  io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [DW-1:0]     io_wdata,
  output logic [DW-1:0]     io_rdata,
  input  logic              pfail_rst_n,
  output logic [DEV_W-1:0]  sram_addr,
  output logic [NUM_CS-1:0] sram_cs_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DW-1:0]     sram_wdata,
  input  logic [DW-1:0]     sram_rdata,
  output logic              act_led
);
  logic              hit;
  port_e             port;
  logic              rd_go, wr_go, acc_now;
  logic              ld_lo, ld_hi;
  logic [FULL_W-1:0] full_addr;
  logic              led_q;

  rdp_decode #(.IOA_W(IOA_W)) u_dec (
    .io_addr (io_addr),
    .base_sw (base_sw),
    .hit     (hit),
    .port    (port)
  );

  assign rd_go   = hit && (port == PORT_DATA) && io_rd;
  assign wr_go   = hit && (port == PORT_DATA) && io_wr;
  assign acc_now = rd_go || wr_go;
  assign ld_lo   = hit && (port == PORT_ALO) && io_wr;
  assign ld_hi   = hit && (port == PORT_AHI) && io_wr;

  rdp_locator #(.BYTE_W(BYTE_W), .LO_W(LO_W), .HI_W(HI_W)) u_loc (
    .clk       (clk),
    .rst       (rst),
    .ld_lo     (ld_lo),
    .ld_hi     (ld_hi),
    .lo_din    (io_wdata[LO_W-1:0]),
    .hi_din    (io_wdata[HI_W-1:0]),
    .acc_now   (acc_now),
    .full_addr (full_addr)
  );

  rdp_sram_side #(.FULL_W(FULL_W), .DEV_W(DEV_W)) u_sram (
    .full_addr (full_addr),
    .rd_go     (rd_go),
    .wr_go     (wr_go),
    .pwr_ok    (pfail_rst_n),
    .sram_addr (sram_addr),
    .cs_n      (sram_cs_n),
    .oe_n      (sram_oe_n),
    .we_n      (sram_we_n)
  );

  assign sram_wdata = io_wdata;

  always_comb begin
    io_rdata = '0;
    if (hit && io_rd) begin
      case (port)
        PORT_DATA: io_rdata = sram_rdata;
        PORT_STAT: io_rdata[0] = pfail_rst_n;
        default:   io_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) led_q <= 1'b0;
    else     led_q <= acc_now;
  end
  assign act_led = led_q;
endmodule

// File: rtl/rdp_checker.sv
module rdp_checker #(
  parameter int IOA_W  = 8,
  parameter int BYTE_W = 9,
  parameter int DEV_W  = 19,
  parameter int NUM_CS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [IOA_W-3:0]  base_sw,
  input logic [IOA_W-1:0]  io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic              pfail_rst_n,
  input logic [DEV_W-1:0]  sram_addr,
  input logic [NUM_CS-1:0] sram_cs_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic              act_led
);
  logic in_win, dsel, awr;
  assign in_win = (io_addr[IOA_W-1:2] == base_sw);
  assign dsel   = in_win && (io_addr[1:0] == 2'd0) && (io_rd || io_wr);
  assign awr    = in_win && io_wr && ((io_addr[1:0] == 2'd1) || (io_addr[1:0] == 2'd2));

  p_pfail_block_r6: assert property (@(posedge clk) disable iff (rst)
    !pfail_rst_n |-> (&sram_cs_n && sram_we_n && sram_oe_n));

  p_cs_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~sram_cs_n));

  p_cs_only_access_r5: assert property (@(posedge clk) disable iff (rst)
    !(&sram_cs_n) |-> dsel);

  p_we_data_wr_r7: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> (io_wr && in_win && io_addr[1:0] == 2'd0 && pfail_rst_n));

  p_addr_clear_r2: assert property (@(posedge clk) disable iff (rst)
    awr |=> (sram_addr[BYTE_W-1:0] == '0));

  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(dsel) && !dsel && !awr) |=>
      (sram_addr[BYTE_W-1:0] == BYTE_W'($past(sram_addr[BYTE_W-1:0]) + 1'b1)));

  p_led_on_r9: assert property (@(posedge clk) disable iff (rst)
    dsel |=> act_led);

  p_led_off_r9: assert property (@(posedge clk) disable iff (rst)
    !dsel |=> !act_led);
endmodule

bind ramdisk_port_ctrl rdp_checker #(
  .IOA_W(IOA_W), .BYTE_W(BYTE_W), .DEV_W(DEV_W), .NUM_CS(NUM_CS)
) u_rdp_chk (
  .clk(clk), .rst(rst), .base_sw(base_sw), .io_addr(io_addr),
  .io_rd(io_rd), .io_wr(io_wr), .pfail_rst_n(pfail_rst_n),
  .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n),
  .sram_we_n(sram_we_n), .act_led(act_led)
);

// File: tb/ramdisk_port_ctrl_test.sv
module ramdisk_port_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  base_sw = 6'h28;
  logic [7:0]  io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        pfail_rst_n = 1'b1;
  logic [18:0] sram_addr;
  logic [7:0]  sram_cs_n;
  logic        sram_oe_n, sram_we_n;
  logic [7:0]  sram_wdata, sram_rdata;
  logic        act_led;

  int checks = 0, errors = 0;
  logic [7:0] m_lo = '0;
  logic [4:0] m_hi = '0;
  logic [8:0] m_off = '0;

  always #10 clk = ~clk;  // 50 MHz

  // Memory stand-in: read data is a function of the address.
  assign sram_rdata = sram_addr[7:0] ^ sram_addr[16:9];

  ramdisk_port_ctrl uut (
    .clk(clk), .rst(rst), .base_sw(base_sw), .io_addr(io_addr),
    .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .pfail_rst_n(pfail_rst_n), .sram_addr(sram_addr), .sram_cs_n(sram_cs_n),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_wdata(sram_wdata),
    .sram_rdata(sram_rdata), .act_led(act_led)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #2 d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  function automatic logic [7:0] base_a(input int k);
    return {base_sw, 2'b00} + 8'(k);
  endfunction

  task automatic set_sector(input logic [7:0] lo, input logic [7:0] hi);
    bus_wr(base_a(1), lo);
    bus_wr(base_a(2), hi);
    m_lo = lo; m_hi = hi[4:0]; m_off = '0;
  endtask

  task automatic data_acc(input bit w, input logic [7:0] wd);
    logic [21:0] ef;
    ef = {m_hi, m_lo, m_off};
    @(negedge clk);
    io_addr = base_a(0); io_wdata = wd;
    if (w) io_wr = 1'b1; else io_rd = 1'b1;
    #2;
    chk(sram_addr == ef[18:0], "R3", "sram_addr", 32'(sram_addr), 32'(ef[18:0]));
    if (pfail_rst_n) begin
      chk(sram_cs_n == ~(8'b1 << ef[21:19]), "R5", "cs_n", 32'(sram_cs_n),
          32'(~(8'b1 << ef[21:19])));
      chk(sram_we_n == !w && sram_oe_n == w, "R7", "we_n/oe_n",
          {sram_we_n, sram_oe_n}, {!w, w});
      if (w) chk(sram_wdata == wd, "R7", "wdata", 32'(sram_wdata), 32'(wd));
      else   chk(io_rdata == (m_off[7:0] ^ m_lo), "R8", "rdata", 32'(io_rdata),
                 32'(m_off[7:0] ^ m_lo));
    end else begin
      chk(&sram_cs_n && sram_we_n && sram_oe_n, "R6", "blocked strobes",
          {sram_cs_n, sram_we_n, sram_oe_n}, 32'h3ff);
    end
    @(negedge clk);
    chk(act_led == 1'b1, "R9", "act_led during access", 32'(act_led), 1);
    io_rd = 1'b0; io_wr = 1'b0;
    m_off = m_off + 1'b1;  // R4 wrap modelled by 9-bit width
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] rd;
    logic [7:0] los[4] = '{8'h00, 8'h5A, 8'hFF, 8'h81};
    logic [7:0] his[4] = '{8'h00, 8'h03, 8'h1F, 8'hE7};
    logic [5:0] bases[5] = '{6'h29, 6'h2A, 6'h2B, 6'h00, 6'h3F};

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R10 reset state
    #2;
    chk(sram_addr == '0, "R10", "addr after reset", 32'(sram_addr), 0);
    chk(act_led == 1'b0, "R10", "led after reset", 32'(act_led), 0);
    chk(&sram_cs_n && sram_we_n && sram_oe_n, "R10", "idle strobes",
        {sram_cs_n, sram_we_n, sram_oe_n}, 32'h3ff);

    // R4/R3/R5 sweep: 514 accesses per sector crosses the 511->0 wrap
    for (int s = 0; s < 4; s++) begin
      set_sector(los[s], his[s]);
      for (int k = 0; k < 514; k++) data_acc(k % 3 == 0, 8'(k * 7 + s));
      chk(sram_addr[16:9] == los[s], "R4", "sector kept after wrap",
          32'(sram_addr[16:9]), 32'(los[s]));
    end
    @(negedge clk);
    chk(act_led == 1'b0, "R9", "led idle", 32'(act_led), 0);

    // R2 clear mid-sector by high-register write alone
    repeat (5) data_acc(1'b0, 8'h00);
    bus_wr(base_a(2), 8'h04);
    m_hi = 5'h04; m_off = '0;
    data_acc(1'b0, 8'h00);

    // R1 base sweep: writes outside the window must be ignored
    for (int b = 0; b < 5; b++) begin
      base_sw = bases[b];
      set_sector(8'(b * 17 + 3), 8'h01);
      bus_wr({base_sw ^ 6'h01, 2'b01}, 8'hEE);
      bus_rd({base_sw ^ 6'h20, 2'b11}, rd);
      chk(rd == 8'h00, "R1", "foreign read", 32'(rd), 0);
      data_acc(1'b0, 8'h00);
    end

    // R8 address-port reads: return 0, no step; status write ignored
    base_sw = 6'h28;
    set_sector(8'h33, 8'h02);
    data_acc(1'b1, 8'hA5);
    bus_rd(base_a(1), rd);
    chk(rd == 8'h00, "R8", "addr-low read", 32'(rd), 0);
    bus_rd(base_a(2), rd);
    chk(rd == 8'h00, "R8", "addr-high read", 32'(rd), 0);
    bus_wr(base_a(3), 8'hFF);
    data_acc(1'b0, 8'h00);  // offset must be 1

    // R6 power fail blocks memory, status reflects it, counter still steps
    bus_rd(base_a(3), rd);
    chk(rd == 8'h01, "R8", "status power good", 32'(rd), 1);
    @(negedge clk); pfail_rst_n = 1'b0;
    bus_rd(base_a(3), rd);
    chk(rd == 8'h00, "R8", "status power fail", 32'(rd), 0);
    data_acc(1'b1, 8'h5C);
    data_acc(1'b0, 8'h00);
    @(negedge clk); pfail_rst_n = 1'b1;
    data_acc(1'b0, 8'h00);

    // R10 reset again mid-sector
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_lo = '0; m_hi = '0; m_off = '0;
    #2 chk(sram_addr == '0, "R10", "addr after second reset", 32'(sram_addr), 0);
    data_acc(1'b0, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule